// File: doc/BRIEF.md
# Power-Management Event Controller

This block keeps the fixed power-management registers of a system controller: a free-running 24-bit timer, an event status word, an event enable word and a control word. All four sit on a small register bus. Next to them sits a pair of byte ports for firmware power commands. The block combines enabled status bits into a level-sensitive system control interrupt. A firmware command can pulse a system-management interrupt. A sleep request written to the control word becomes a one-cycle shutdown request or a one-cycle reset request.

The timer advances on each clock where `tick_en` is high. The integration supplies `tick_en` at the 3.579545 MHz rate. Whenever the count crosses a multiple of 2^CARRY_BIT, the timer overflow flag is set; the default CARRY_BIT of 23 gives a boundary every 0x800000 counts. A power-button event raises its status flag only when its enable bit is set. Status flags are cleared by writing ones to them.

Top module: `pm_event_ctrl`

## Requirements
- R1: After a synchronous reset, the status, enable, control and timer registers and both command bytes read zero, and `sci`, `smi`, `shutdown_req` and `reset_req` are low.
- R2: The timer adds one on each clock with `tick_en` high and holds otherwise. A bus read at offset 0x08 returns the 24-bit count zero-extended to 32 bits.
- R3: The 6-bit bus offset selects status at 0x00, enable at 0x02 and control at 0x04, each holding 16 bits. Every other offset reads zero and ignores writes; the timer offset cannot be written.
- R4: A status write clears each bit written as 1 and leaves the others. A hardware set that lands in the same cycle as a clear of that bit wins.
- R5: Status bit 0 sets on every tick that brings the count onto a multiple of 2^CARRY_BIT and stays set until cleared. After a clear it sets again only at the next boundary.
- R6: `sci` is high exactly while (status AND enable AND 0x0521) is nonzero. It follows the registers on the same clock edge.
- R7: A control write stores every bit except bit 13, which always reads 0.
- R8: A control write with bit 13 set and bits 12:10 = 0 gives a one-cycle `shutdown_req` pulse in the cycle after the write.
- R9: A control write with bit 13 set and bits 12:10 = 1 sets status bits 15 and 8 and gives a one-cycle `reset_req` pulse. Any other sleep type, or bit 13 clear, gives no pulse.
- R10: A `pwr_btn` cycle sets status bit 8 only while enable bit 8 is set.
- R11: A command-port write (`apm_sel`=0) of 0xF1 sets control bit 0, and a write of 0xF0 clears it. Any other value leaves control bit 0 alone. The last command reads back.
- R12: Each command-port write gives a one-cycle `smi` pulse when `smi_en` is high, and none when it is low. Writes to the status port never give one.
- R13: The status port (`apm_sel`=1) is plain 8-bit storage that reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer advance enable |
| pwr_btn | input | 1 | Power-button event, one cycle per press |
| smi_en | input | 1 | Allows command writes to raise `smi` |
| bus_addr | input | 6 | Register offset in the 64-byte window |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| apm_sel | input | 1 | 0 selects the command byte, 1 the status byte |
| apm_wr | input | 1 | Byte port write strobe |
| apm_rd | input | 1 | Byte port read strobe |
| apm_wdata | input | 8 | Byte port write data |
| apm_rdata | output | 8 | Registered byte port read data |
| sci | output | 1 | Level system control interrupt |
| smi | output | 1 | System-management interrupt pulse |
| shutdown_req | output | 1 | Soft-off request pulse |
| reset_req | output | 1 | Resume-through-reset request pulse |

## Verification
Software clearing a status flag and hardware raising the same flag can fall into one cycle. This happens with the power-button flag and with the timer overflow flag. The bench provokes it by driving `pwr_btn` on the very edge where a status write clears bit 8, with enable bit 8 set. It then reads the status word back: bit 8 must still be 1, and `sci` must stay high. Overflow, sleep-type and command writes are each checked through register reads made after the stimulus.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 6;
  localparam int RD_W   = 32;

  localparam logic [ADDR_W-1:0] OFF_STS = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_EN  = 6'h02;
  localparam logic [ADDR_W-1:0] OFF_CTL = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_TMR = 6'h08;

  localparam int B_TMR   = 0;
  localparam int B_GBL   = 5;
  localparam int B_PWR   = 8;
  localparam int B_RTC   = 10;
  localparam int B_SLP   = 13;
  localparam int B_WAKE  = 15;
  localparam int B_SCIEN = 0;

  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << B_RTC) | (1 << B_PWR) | (1 << B_GBL) | (1 << B_TMR));

  localparam logic [7:0] CMD_ON  = 8'hF1;
  localparam logic [7:0] CMD_OFF = 8'hF0;

  typedef struct packed {
    logic off;
    logic resume;
  } slp_act_t;
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
  parameter int W         = 24,
  parameter int CARRY_BIT = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  output logic [W-1:0] cnt,
  output logic         crossing
);
  localparam logic [CARRY_BIT-1:0] LOW_ONES = '1;
  localparam logic [W-1:0]         ONE      = W'(1);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (tick_en) cnt <= cnt + ONE;
  end

  // the next tick lands on a multiple of 2^CARRY_BIT
  assign crossing = tick_en && (cnt[CARRY_BIT-1:0] == LOW_ONES);

  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> cnt == $past(cnt) + ONE);
  // R2
  tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt));
endmodule

// File: rtl/pm_sleep_decode.sv
module pm_sleep_decode
  import pm_evt_pkg::*;
(
  input  logic       wr,
  input  logic [3:0] sel,
  output slp_act_t   act
);
  logic       go;
  logic [2:0] typ;

  assign go         = wr && sel[3];
  assign typ        = sel[2:0];
  assign act.off    = go && (typ == 3'd0);
  assign act.resume = go && (typ == 3'd1);
endmodule

// File: rtl/pm_apm_port.sv
module pm_apm_port
  import pm_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  logic       smi_en,
  output logic [7:0] rdata,
  output logic       smi,
  output logic       sci_on,
  output logic       sci_off
);
  logic [7:0] cmd_q, sts_q;
  logic       cmd_wr;

  assign cmd_wr  = wr && !sel;
  assign sci_on  = cmd_wr && (wdata == CMD_ON);
  assign sci_off = cmd_wr && (wdata == CMD_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      sts_q <= '0;
      smi   <= 1'b0;
      rdata <= '0;
    end else begin
      if (cmd_wr)    cmd_q <= wdata;
      if (wr && sel) sts_q <= wdata;
      smi   <= cmd_wr && smi_en;
      rdata <= rd ? (sel ? sts_q : cmd_q) : 8'h00;
    end
  end

  // R12
  smi_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && (sel || !smi_en)) |=> !smi);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int TMR_W     = 24,
  parameter int CARRY_BIT = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              pwr_btn,
  input  logic              smi_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  input  logic              apm_sel,
  input  logic              apm_wr,
  input  logic              apm_rd,
  input  logic [7:0]        apm_wdata,
  output logic [7:0]        apm_rdata,
  output logic              sci,
  output logic              smi,
  output logic              shutdown_req,
  output logic              reset_req
);
  localparam logic [REG_W-1:0] SLP_KEEP = ~(REG_W'(1) << B_SLP);

  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic [REG_W-1:0] sts_d, en_d, ctl_d;
  logic [TMR_W-1:0] tmr_cnt;
  logic             crossing;
  logic             wr_sts, wr_en, wr_ctl;
  logic             sci_on, sci_off;
  slp_act_t         act;
  logic [RD_W-1:0]  rd_mux;

  pm_tick_timer #(.W(TMR_W), .CARRY_BIT(CARRY_BIT)) u_tmr (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt(tmr_cnt), .crossing(crossing)
  );

  pm_apm_port u_apm (
    .clk(clk), .rst(rst), .sel(apm_sel), .wr(apm_wr), .rd(apm_rd),
    .wdata(apm_wdata), .smi_en(smi_en), .rdata(apm_rdata), .smi(smi),
    .sci_on(sci_on), .sci_off(sci_off)
  );

  assign wr_sts = bus_wr && (bus_addr == OFF_STS);
  assign wr_en  = bus_wr && (bus_addr == OFF_EN);
  assign wr_ctl = bus_wr && (bus_addr == OFF_CTL);

  pm_sleep_decode u_slp (
    .wr(wr_ctl), .sel(bus_wdata[B_SLP:B_SLP-3]), .act(act)
  );

  // status: clears first, hardware sets override
  always_comb begin
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_q & ~bus_wdata;
    if (crossing) sts_d[B_TMR] = 1'b1;
    if (pwr_btn && en_q[B_PWR]) sts_d[B_PWR] = 1'b1;
    if (act.resume) begin
      sts_d[B_WAKE] = 1'b1;
      sts_d[B_PWR]  = 1'b1;
    end
  end

  assign en_d = wr_en ? bus_wdata : en_q;

  // control: bus write first, command port has the last word on bit 0
  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl)  ctl_d = bus_wdata & SLP_KEEP;
    if (sci_on)  ctl_d[B_SCIEN] = 1'b1;
    if (sci_off) ctl_d[B_SCIEN] = 1'b0;
  end

  always_comb begin
    case (bus_addr)
      OFF_STS: rd_mux = RD_W'(sts_q);
      OFF_EN:  rd_mux = RD_W'(en_q);
      OFF_CTL: rd_mux = RD_W'(ctl_q);
      OFF_TMR: rd_mux = RD_W'(tmr_cnt);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q        <= '0;
      en_q         <= '0;
      ctl_q        <= '0;
      sci          <= 1'b0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      bus_rdata    <= '0;
    end else begin
      sts_q        <= sts_d;
      en_q         <= en_d;
      ctl_q        <= ctl_d;
      sci          <= |(sts_d & en_d & SCI_MASK);
      shutdown_req <= act.off;
      reset_req    <= act.resume;
      bus_rdata    <= bus_rd ? rd_mux : '0;
    end
  end

  // R6
  sci_level_chk: assert property (@(posedge clk) disable iff (rst)
    sci == |(sts_q & en_q & SCI_MASK));
  // R5
  tmr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    crossing |=> sts_q[B_TMR]);
  // R9
  wake_sts_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (sts_q[B_WAKE] && sts_q[B_PWR]));
  // R10
  pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_btn && !en_q[B_PWR] && !sts_q[B_PWR] && !act.resume) |=> !sts_q[B_PWR]);
  // R7
  slp_bit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> !ctl_q[B_SLP]);
endmodule

// File: tb/sim_pm_event_ctrl.sv
module sim_pm_event_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, pwr_btn = 1'b0, smi_en = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        apm_sel = 1'b0, apm_wr = 1'b0, apm_rd = 1'b0;
  logic [7:0]  apm_wdata = '0;
  logic [7:0]  apm_rdata;
  logic        sci, smi, shutdown_req, reset_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pm_event_ctrl #(.TMR_W(24), .CARRY_BIT(7)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pwr_btn(pwr_btn), .smi_en(smi_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .apm_sel(apm_sel), .apm_wr(apm_wr), .apm_rd(apm_rd),
    .apm_wdata(apm_wdata), .apm_rdata(apm_rdata), .sci(sci), .smi(smi),
    .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic awr(input logic s, input logic [7:0] d);
    @(negedge clk);
    apm_sel = s; apm_wdata = d; apm_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    apm_wr = 1'b0;
  endtask

  task automatic ard(input logic s, output logic [7:0] d);
    @(negedge clk);
    apm_sel = s; apm_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    apm_rd = 1'b0;
    d = apm_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [7:0]  b;
    chk("R1 outputs", {28'd0, sci, smi, shutdown_req, reset_req}, 32'd0);
    brd(6'h00, v); chk("R1 status", v, 32'd0);
    brd(6'h02, v); chk("R1 enable", v, 32'd0);
    brd(6'h04, v); chk("R1 control", v, 32'd0);
    brd(6'h08, v); chk("R1 timer", v, 32'd0);
    ard(1'b0, b);  chk("R1 cmd byte", {24'd0, b}, 32'd0);
    ard(1'b1, b);  chk("R1 sts byte", {24'd0, b}, 32'd0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    ticks(5);
    brd(6'h08, v); chk("R2 count 5", v, 32'd5);
    repeat (4) @(posedge clk);
    brd(6'h08, v); chk("R2 hold", v, 32'd5);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    ticks(122);
    brd(6'h08, v); chk("R2 count 127", v, 32'd127);
    brd(6'h00, v); chk("R5 before boundary", v, 32'd0);
    ticks(1);
    brd(6'h00, v); chk("R5 at boundary", v, 32'h0001);
    bwr(6'h02, 16'h0001);
    chk("R6 sci on", {31'd0, sci}, 32'd1);
    bwr(6'h00, 16'h0001);
    chk("R6 sci off after clear", {31'd0, sci}, 32'd0);
    brd(6'h00, v); chk("R4 cleared", v, 32'd0);
    ticks(72);
    brd(6'h00, v); chk("R5 re-armed mid", v, 32'd0);
    ticks(56);
    brd(6'h00, v); chk("R5 next boundary", v, 32'h0001);
    brd(6'h08, v); chk("R2 count 256", v, 32'd256);
    bwr(6'h00, 16'hFFFF);
    bwr(6'h02, 16'h0000);
  endtask

  task automatic t_pwr();
    logic [31:0] v;
    @(negedge clk); pwr_btn = 1'b1;
    @(negedge clk); pwr_btn = 1'b0;
    brd(6'h00, v); chk("R10 gated off", v, 32'd0);
    bwr(6'h02, 16'h0100);
    @(negedge clk); pwr_btn = 1'b1;
    @(negedge clk); pwr_btn = 1'b0;
    brd(6'h00, v); chk("R10 set", v, 32'h0100);
    chk("R6 sci pwr", {31'd0, sci}, 32'd1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    @(negedge clk);
    bus_addr = 6'h00; bus_wdata = 16'h0100; bus_wr = 1'b1; pwr_btn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; pwr_btn = 1'b0;
    chk("R4 sci held on collide", {31'd0, sci}, 32'd1);
    brd(6'h00, v); chk("R4 set wins over clear", v, 32'h0100);
    bwr(6'h00, 16'h0100);
    brd(6'h00, v); chk("R4 clear alone", v, 32'd0);
  endtask

  task automatic t_sleep();
    logic [31:0] v;
    bwr(6'h04, 16'h2000);
    chk("R8 shutdown pulse", {30'd0, shutdown_req, reset_req}, 32'b10);
    @(negedge clk);
    chk("R8 pulse ends", {30'd0, shutdown_req, reset_req}, 32'b00);
    brd(6'h04, v); chk("R7 bit13 dropped", v, 32'd0);
    bwr(6'h04, 16'h2400);
    chk("R9 reset pulse", {30'd0, shutdown_req, reset_req}, 32'b01);
    brd(6'h00, v); chk("R9 wake status", v, 32'h8100);
    bwr(6'h00, 16'h8000);
    brd(6'h00, v); chk("R4 partial clear", v, 32'h0100);
    bwr(6'h00, 16'h0100);
    bwr(6'h04, 16'h2802);
    chk("R9 type2 no pulse", {30'd0, shutdown_req, reset_req}, 32'b00);
    brd(6'h04, v); chk("R7 type2 stored", v, 32'h0802);
    bwr(6'h04, 16'h1C05);
    chk("R9 no sleep bit", {30'd0, shutdown_req, reset_req}, 32'b00);
    brd(6'h04, v); chk("R7 plain store", v, 32'h1C05);
    bwr(6'h04, 16'h0000);
  endtask

  task automatic t_apm();
    logic [31:0] v;
    logic [7:0]  b;
    smi_en = 1'b1;
    awr(1'b0, 8'hF1);
    chk("R12 smi pulse", {31'd0, smi}, 32'd1);
    @(negedge clk);
    chk("R12 smi ends", {31'd0, smi}, 32'd0);
    brd(6'h04, v); chk("R11 enable cmd", v, 32'h0001);
    awr(1'b0, 8'h55);
    brd(6'h04, v); chk("R11 other cmd keeps", v, 32'h0001);
    ard(1'b0, b);  chk("R11 cmd readback", {24'd0, b}, 32'h55);
    awr(1'b0, 8'hF0);
    brd(6'h04, v); chk("R11 disable cmd", v, 32'h0000);
    smi_en = 1'b0;
    awr(1'b0, 8'hF1);
    chk("R12 no smi when gated", {31'd0, smi}, 32'd0);
    smi_en = 1'b1;
    awr(1'b1, 8'hA5);
    chk("R12 no smi on sts byte", {31'd0, smi}, 32'd0);
    ard(1'b1, b); chk("R13 sts byte", {24'd0, b}, 32'hA5);
    ard(1'b0, b); chk("R13 cmd untouched", {24'd0, b}, 32'hF1);
    smi_en = 1'b0;
  endtask

  task automatic t_undecoded();
    logic [31:0] v;
    bwr(6'h0C, 16'hFFFF);
    brd(6'h0C, v); chk("R3 undecoded read", v, 32'd0);
    brd(6'h06, v); chk("R3 gap read", v, 32'd0);
    brd(6'h02, v); chk("R3 enable untouched", v, 32'h0100);
    bwr(6'h08, 16'h1234);
    brd(6'h08, v); chk("R3 timer not writable", v, 32'd256);
    brd(6'h00, v); chk("R3 status untouched", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timer();
    t_overflow();
    t_pwr();
    t_same_cycle();
    t_sleep();
    t_apm();
    t_undecoded();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule